// File: doc/BRIEF.md
# Back-up Mode Wakeup and Restart Controller

This block manages the low-power back-up state of a small 4-bit microcontroller core. When the core requests back-up entry, the block halts the core and sets a power-down flag. While the core is halted, the block watches a set of key input groups and one shared pin. The shared pin serves either as an interrupt input or as one more key bit.

A wakeup is declared when a valid level is seen on two consecutive synchronized samples. A wakeup releases the core and loads the restart vector, which is address 0 of page 0. Reset also loads that vector, but it clears the flag. Software reads the flag after restart to tell a warm start (flag 1) from a cold start (flag 0).

The shared pin has two modes. In interrupt mode it wakes on a programmable level. A wakeup through that pin never raises the interrupt-request strobe; the strobe fires only for real interrupt edges while the core runs. In key mode the pin wakes only on a low level, and only when its owning key group is enabled.

Top module: `backup_wake_ctrl`

## Requirements
- R1: While `rst` is high (sampled at a rising edge), `core_halt`=0, `core_run`=1, `pd_flag`=0, `irq_flag_set`=0 and `vec_load`=1; on the first edge after release `vec_load` returns to 0.
- R2: `enter_req` seen at an edge while the core runs gives `core_halt`=1, `core_run`=0 and `pd_flag`=1 after that edge; `enter_req` while already halted changes nothing.
- R3: While halted, an enabled key group (`key_en[g]`=1, pins `key_pins[4g+3:4g]`) with any pin low wakes the core: `core_halt` falls after the fourth rising edge following the pin change, not after the third. A group with `key_en[g]`=0 never wakes.
- R4: A wake level lasting only one sampled cycle is rejected and the core stays halted.
- R5: With `shared_as_key`=0 the shared pin wakes when its level equals `irq_wake_high` (1 means high, 0 means low), independent of `key_en`.
- R6: With `shared_as_key`=1 the shared pin wakes only when low, and only if `key_en[1]`=1; a high level never wakes.
- R7: On wakeup `vec_load` is 1 for exactly one cycle, together with the fall of `core_halt`, and `pd_flag` stays 1.
- R8: While running with `shared_as_key`=0, the shared pin entering its active level gives one `irq_flag_set` pulse after the third rising edge. The strobe is never raised while halted or by a wakeup through the shared pin.
- R9: While the core runs, wake levels on any input have no effect: `core_halt` and `vec_load` stay 0.
- R10: Reset in the same cycle as a qualified wakeup wins: afterwards `pd_flag`=0, `core_halt`=0, `vec_load`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter the back-up state |
| key_en | input | NKEY (5) | Per-group key wakeup enable |
| shared_as_key | input | 1 | 1: shared pin is a key bit; 0: interrupt input |
| irq_wake_high | input | 1 | Interrupt-mode active level (1 high, 0 low) |
| key_pins | input | NKEY*GRP_W (20) | Key pin levels, group g at bits 4g+3..4g |
| shared_pin | input | 1 | Shared interrupt/key pin level |
| core_halt | output | 1 | Core halted (back-up state) |
| core_run | output | 1 | Core allowed to run |
| vec_load | output | 1 | Load restart vector (page 0, address 0) |
| pd_flag | output | 1 | Power-down flag: 1 warm start, 0 cold start |
| irq_flag_set | output | 1 | Strobe to set the external interrupt request flag |

## Verification
The main function is driven from a vector table. Each row pairs a group-enable mask and a pin pattern with the shared-pin mode and level. Low pins in enabled and in disabled groups separate correct enable gating from a plain any-pin-low OR. Interrupt mode is tried at both active levels, and key mode with its group on and off and with a high level. These rows catch a swapped polarity or a mode select that leaks into the other path. Directed cases cover a one-cycle glitch, the three-versus-four edge latency, reset against a simultaneous wakeup, and the interrupt strobe while running versus while halted.

// File: rtl/backup_wake_pkg.sv
package backup_wake_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} pd_state_t;
endpackage

// File: rtl/backup_wake_sync.sv
module backup_wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_new,
  output logic [W-1:0] q_old
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta  <= d;
    q_new <= meta;
    q_old <= q_new;
  end
endmodule

// File: rtl/backup_wake_detect.sv
module backup_wake_detect #(
  parameter int NKEY       = 5,
  parameter int GRP_W      = 4,
  parameter int SHARED_GRP = 1
) (
  input  logic [NKEY-1:0]       key_en,
  input  logic                  shared_as_key,
  input  logic                  irq_wake_high,
  input  logic [NKEY*GRP_W-1:0] keys,
  input  logic                  shared,
  output logic                  wake,
  output logic                  irq_active
);
  logic [NKEY-1:0] grp_hit;

  for (genvar g = 0; g < NKEY; g++) begin : g_grp
    assign grp_hit[g] = key_en[g] && !(&keys[g*GRP_W +: GRP_W]);
  end

  logic shared_hit;
  always_comb begin
    irq_active = !shared_as_key && (shared == irq_wake_high);
    if (shared_as_key) shared_hit = key_en[SHARED_GRP] && !shared;
    else               shared_hit = irq_active;
  end

  assign wake = (|grp_hit) || shared_hit;
endmodule

// File: rtl/backup_wake_fsm.sv
module backup_wake_fsm
  import backup_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic wake_ok,
  input  logic irq_edge,
  output logic core_halt,
  output logic core_run,
  output logic vec_load,
  output logic pd_flag,
  output logic irq_flag_set
);
  pd_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      core_halt    <= 1'b0;
      core_run     <= 1'b1;
      vec_load     <= 1'b1;
      pd_flag      <= 1'b0;
      irq_flag_set <= 1'b0;
    end else begin
      vec_load     <= 1'b0;
      irq_flag_set <= 1'b0;
      case (state)
        ST_RUN: begin
          irq_flag_set <= irq_edge;
          if (enter_req) begin
            state     <= ST_HALT;
            core_halt <= 1'b1;
            core_run  <= 1'b0;
            pd_flag   <= 1'b1;
          end
        end
        ST_HALT: begin
          if (wake_ok) begin
            state     <= ST_RUN;
            core_halt <= 1'b0;
            core_run  <= 1'b1;
            vec_load  <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/backup_wake_ctrl.sv
module backup_wake_ctrl #(
  parameter int NKEY       = 5,
  parameter int GRP_W      = 4,
  parameter int SHARED_GRP = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enter_req,
  input  logic [NKEY-1:0]       key_en,
  input  logic                  shared_as_key,
  input  logic                  irq_wake_high,
  input  logic [NKEY*GRP_W-1:0] key_pins,
  input  logic                  shared_pin,
  output logic                  core_halt,
  output logic                  core_run,
  output logic                  vec_load,
  output logic                  pd_flag,
  output logic                  irq_flag_set
);
  localparam int KW = NKEY * GRP_W;
  localparam int SW = KW + 1;

  logic [SW-1:0] s_new, s_old;

  backup_wake_sync #(.W(SW)) u_sync (
    .clk(clk), .d({shared_pin, key_pins}), .q_new(s_new), .q_old(s_old)
  );

  logic wake_new, wake_old, irq_new, irq_old;

  backup_wake_detect #(.NKEY(NKEY), .GRP_W(GRP_W), .SHARED_GRP(SHARED_GRP)) u_det_new (
    .key_en(key_en), .shared_as_key(shared_as_key), .irq_wake_high(irq_wake_high),
    .keys(s_new[KW-1:0]), .shared(s_new[KW]), .wake(wake_new), .irq_active(irq_new)
  );

  backup_wake_detect #(.NKEY(NKEY), .GRP_W(GRP_W), .SHARED_GRP(SHARED_GRP)) u_det_old (
    .key_en(key_en), .shared_as_key(shared_as_key), .irq_wake_high(irq_wake_high),
    .keys(s_old[KW-1:0]), .shared(s_old[KW]), .wake(wake_old), .irq_active(irq_old)
  );

  backup_wake_fsm u_fsm (
    .clk(clk), .rst(rst), .enter_req(enter_req),
    .wake_ok(wake_new && wake_old),
    .irq_edge(irq_new && !irq_old),
    .core_halt(core_halt), .core_run(core_run), .vec_load(vec_load),
    .pd_flag(pd_flag), .irq_flag_set(irq_flag_set)
  );
endmodule

// File: rtl/backup_wake_ctrl_chk.sv
module backup_wake_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic enter_req,
  input logic core_halt,
  input logic vec_load,
  input logic pd_flag,
  input logic irq_flag_set
);
  p_reset_cold_r1: assert property (@(posedge clk) rst |=> (!pd_flag && !core_halt && vec_load));

  p_enter_halts_r2: assert property (@(posedge clk) disable iff (rst)
    (!core_halt && enter_req) |=> (core_halt && pd_flag));

  p_flag_rise_from_enter_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> $past(enter_req));

  p_wake_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(core_halt) && !$past(rst)) |-> (vec_load && pd_flag));

  p_vec_single_r7: assert property (@(posedge clk) disable iff (rst)
    vec_load |=> !vec_load);

  p_no_irq_halted_r8: assert property (@(posedge clk) disable iff (rst)
    core_halt |=> !irq_flag_set);
endmodule

bind backup_wake_ctrl backup_wake_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enter_req(enter_req), .core_halt(core_halt),
  .vec_load(vec_load), .pd_flag(pd_flag), .irq_flag_set(irq_flag_set)
);

// File: tb/backup_wake_ctrl_test.sv
module backup_wake_ctrl_test;
  localparam int CYC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_req = 1'b0;
  logic [4:0] key_en = '0;
  logic shared_as_key = 1'b0;
  logic irq_wake_high = 1'b0;
  logic [19:0] key_pins = '1;
  logic shared_pin = 1'b1;
  logic core_halt, core_run, vec_load, pd_flag, irq_flag_set;

  always #(CYC/2) clk = ~clk;

  backup_wake_ctrl uut (
    .clk(clk), .rst(rst), .enter_req(enter_req), .key_en(key_en),
    .shared_as_key(shared_as_key), .irq_wake_high(irq_wake_high),
    .key_pins(key_pins), .shared_pin(shared_pin),
    .core_halt(core_halt), .core_run(core_run), .vec_load(vec_load),
    .pd_flag(pd_flag), .irq_flag_set(irq_flag_set)
  );

  int n_run = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  // {key_en[4:0], key_pins[19:0], shared, as_key, wake_high, expect_wake}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {5'b00001, 20'hFFFFE, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 enabled group 0
    {5'b00000, 20'hFFFFE, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 disabled
    {5'b10000, 20'h7FFFF, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 group 4
    {5'b01110, 20'hFFFF0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 low in disabled group
    {5'b00000, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 high active
    {5'b00000, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 low active
    {5'b00010, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 key mode low
    {5'b00000, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 group off
    {5'b00010, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b0}   // R6 high ignored
  };

  always @(posedge clk) if (irq_flag_set) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_pins();
    key_pins = '1;
    shared_pin = shared_as_key ? 1'b1 : ~irq_wake_high;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(4);
  endtask

  task automatic do_enter();
    enter_req = 1'b1;
    step(1);
    enter_req = 1'b0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(2);
    // R1 reset state
    chk("R1 halt", core_halt, 0);
    chk("R1 run", core_run, 1);
    chk("R1 flag", pd_flag, 0);
    chk("R1 vec", vec_load, 1);
    chk("R1 irq", irq_flag_set, 0);
    rst = 1'b0;
    step(1);
    chk("R1 vec release", vec_load, 0);

    for (int i = 0; i < NV; i++) begin
      key_en = VEC[i][28:24];
      shared_as_key = VEC[i][2];
      irq_wake_high = VEC[i][1];
      idle_pins();
      do_reset();
      do_enter();
      chk("R2 halted", core_halt, 1);
      chk("R2 flag", pd_flag, 1);
      key_pins = VEC[i][23:4];
      shared_pin = VEC[i][3];
      step(3);
      chk("R3 latency", core_halt, 1);
      step(1);
      chk("R3 R5 R6 wake", core_halt, !VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R7 vec", vec_load, 1);
        chk("R7 flag", pd_flag, 1);
        step(1);
        chk("R7 vec one cycle", vec_load, 0);
      end
    end

    // R2 enter while halted ignored, R4 glitch
    key_en = 5'b11111; shared_as_key = 1'b0; irq_wake_high = 1'b0;
    idle_pins();
    do_reset();
    do_enter();
    do_enter();
    chk("R2 reenter", core_halt, 1);
    chk("R2 reenter vec", vec_load, 0);
    key_pins[5] = 1'b0;
    step(1);
    key_pins[5] = 1'b1;
    step(6);
    chk("R4 glitch", core_halt, 1);
    chk("R4 glitch vec", vec_load, 0);

    // R8 wake through shared pin raises no strobe
    irq_cnt = 0;
    shared_pin = 1'b0;
    step(4);
    chk("R8 shared wake", core_halt, 0);
    step(3);
    chk("R8 no strobe on wake", irq_cnt, 0);

    // R9 running ignores wake levels
    key_pins = 20'h00000;
    step(6);
    chk("R9 halt", core_halt, 0);
    chk("R9 vec", vec_load, 0);
    key_pins = '1;

    // R8 strobe while running
    irq_wake_high = 1'b1;
    shared_pin = 1'b0;
    step(4);
    irq_cnt = 0;
    shared_pin = 1'b1;
    step(2);
    chk("R8 not yet", irq_flag_set, 0);
    step(1);
    chk("R8 pulse", irq_flag_set, 1);
    step(4);
    chk("R8 single", irq_cnt, 1);

    // R10 reset wins over wakeup
    irq_wake_high = 1'b0;
    idle_pins();
    do_reset();
    do_enter();
    key_pins[0] = 1'b0;
    step(3);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    chk("R10 flag", pd_flag, 0);
    chk("R10 halt", core_halt, 0);
    chk("R10 vec", vec_load, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule